// File: doc/BRIEF.md
# Dual-Channel I/Q Serial Output Formatter

This block sits behind a pair of digital down-converter channels. Each time `in_valid` pulses, it captures four 32-bit two's-complement words: the in-phase and quadrature samples of channel A and of channel B. It reduces each word to one of four number formats and presents the results on four parallel outputs. It then shifts the reduced words out MSB first, one bit per clock, with a frame-sync strobe and a ready level. The configuration inputs are sampled only in the cycle a sample set is accepted. They choose the number format, the polarity of the frame-sync and ready outputs, whether frame-sync marks every word or every I/Q pair, and whether channel B gets its own pin or follows channel A on the A pin.

The sequencer is a three-state machine. IDLE waits for a sample. SYNC is the one bit period in which frame-sync is active. SHIFT sends the data bits. The transitions are:
- IDLE→SYNC on an accepted sample (*accept*).
- SYNC→SHIFT always (*sync_done*).
- SHIFT→SHIFT while bits remain in a word, or when the I word ends in pair mode (*bit_next*).
- SHIFT→SYNC at the end of a word that is followed by a word needing its own sync (*word_next*).
- SHIFT→IDLE after the last bit of the last word (*frame_done*).

A sample that arrives outside IDLE is discarded.

Top module: `iq_serial_formatter`

## Requirements
- R1: After reset, `sd_a`, `sd_b`, `fs`, `rdy` and `overrun` are 0 and all parallel outputs are zero. Outside a frame, `sd_a` and `sd_b` are 0 and `fs` sits at its inactive level.
- R2: Format code 0 passes the whole 32-bit word to the parallel output. The serial word is its 8 most significant bits.
- R3: Format codes 1 and 2 round to the top 16 and 24 bits respectively. Rounding adds the bit just below the kept field. A result that would pass the largest positive value saturates to it. The dropped low bits of the parallel word are 0. The serial word is the kept field.
- R4: Format code 3 counts the leading bits that repeat the sign bit, capped at 15, and shifts the word left by that count. Parallel bits [31:24] hold the top 8 bits of the shifted word, bits [23:20] hold the count, and the rest are 0. The serial word is those 12 bits, mantissa first.
- R5: Serial data goes out MSB first, one bit per clock, beginning in the clock after the frame-sync period. The I word always precedes the Q word.
- R6: With `cfg_pair`=0, each word is preceded by one clock of active frame-sync, during which the data pins are 0.
- R7: With `cfg_pair`=1, frame-sync is active only in the clock before each I/Q pair, and the Q word follows the I word with no gap.
- R8: With `cfg_mux`=0, channel A goes out on `sd_a` and channel B on `sd_b` at the same time. With `cfg_mux`=1, channel A's pair and then channel B's pair go out on `sd_a`, and `sd_b` stays 0.
- R9: `fs` is active high when the latched `cfg_fs_inv` is 0 and active low when it is 1.
- R10: `rdy` becomes active in the clock after a sample is accepted and stays active through the last data bit. Its active level is high for `cfg_rdy_inv`=0 and low for 1. It is active for 2W+2 clocks per frame in per-word mode (W = serial word length).
- R11: An `in_valid` pulse during a frame is discarded. `overrun` is 1 for exactly the following clock, and the parallel outputs and the frame in progress are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe marking a new sample set |
| a_i | input | 32 | Channel A in-phase sample |
| a_q | input | 32 | Channel A quadrature sample |
| b_i | input | 32 | Channel B in-phase sample |
| b_q | input | 32 | Channel B quadrature sample |
| cfg_fs_inv | input | 1 | Frame-sync polarity (1 = active low) |
| cfg_rdy_inv | input | 1 | Ready polarity (1 = active low) |
| cfg_mux | input | 1 | 1 = both channels on `sd_a` |
| cfg_pair | input | 1 | 1 = one sync per I/Q pair |
| cfg_fmt | input | 2 | Number format code 0..3 |
| sd_a | output | 1 | Serial data, channel A (or both) |
| sd_b | output | 1 | Serial data, channel B |
| fs | output | 1 | Frame-sync strobe |
| rdy | output | 1 | Data-ready level |
| overrun | output | 1 | One-clock flag for a discarded sample |
| par_a_i | output | 32 | Formatted channel A in-phase word |
| par_a_q | output | 32 | Formatted channel A quadrature word |
| par_b_i | output | 32 | Formatted channel B in-phase word |
| par_b_q | output | 32 | Formatted channel B quadrature word |

## Verification
The format path is driven with words chosen to separate its cases:
- a round bit of exactly one half against one just below it, which shows rounding from truncation;
- the largest positive kept value with the round bit set, which shows saturation from wraparound;
- minus one half, which shows that negative rounding carries through zero;
- zero, all ones and a small positive word, which show the exponent cap against plain normalization.

The framing tests use distinct byte patterns on the four words, so that a wrong word order, a missing sync period or a channel sent on the wrong pin changes the bit stream that is seen. Polarity and overrun tests read the idle levels after the frame and the parallel outputs just after the discarded pulse.

// File: rtl/iqf_pkg.sv
`timescale 1ns/1ps
package iqf_pkg;
    localparam int TRUNC_W  = 8;
    localparam int RND_LO_W = 16;
    localparam int RND_HI_W = 24;
    localparam int MANT_W   = 8;
    localparam int EXP_W    = 4;
    localparam int LW       = 5;

    typedef enum logic [1:0] {
        FMT_TRUNC8 = 2'd0,
        FMT_RND16  = 2'd1,
        FMT_RND24  = 2'd2,
        FMT_FLOAT  = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SYNC  = 2'd1,
        ST_SHIFT = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic fs_inv;
        logic rdy_inv;
        logic mux;
        logic pair;
        fmt_e fmt;
    } cfg_t;

    function automatic logic [LW-1:0] word_len(fmt_e f);
        unique case (f)
            FMT_TRUNC8: return LW'(TRUNC_W);
            FMT_RND16:  return LW'(RND_LO_W);
            FMT_RND24:  return LW'(RND_HI_W);
            FMT_FLOAT:  return LW'(MANT_W + EXP_W);
            default:    return LW'(TRUNC_W);
        endcase
    endfunction
endpackage

// File: rtl/iqf_round.sv
`timescale 1ns/1ps
module iqf_round #(
    parameter int DW = 32,
    parameter int KW = 16
) (
    input  logic [DW-1:0] x,
    output logic [DW-1:0] y
);
    localparam int DROP = DW - KW;
    localparam logic [KW-1:0] MAXP = {1'b0, {(KW-1){1'b1}}};

    logic [KW-1:0] kept;
    logic [KW-1:0] rnd;
    logic          rbit;

    always_comb begin
        kept = x[DW-1 -: KW];
        rbit = x[DROP-1];
        rnd  = (rbit && kept == MAXP) ? MAXP : kept + KW'(rbit);
        y    = {rnd, {DROP{1'b0}}};
    end
endmodule

// File: rtl/iqf_float.sv
`timescale 1ns/1ps
module iqf_float #(
    parameter int DW = 32,
    parameter int MW = 8,
    parameter int EW = 4
) (
    input  logic [DW-1:0] x,
    output logic [DW-1:0] y
);
    localparam int CW   = $clog2(DW) + 1;
    localparam int EMAX = (2 ** EW) - 1;

    logic [CW-1:0] cnt;
    logic          run;
    logic [EW-1:0] expo;
    logic [DW-1:0] shifted;

    always_comb begin
        cnt = '0;
        run = 1'b1;
        for (int k = DW - 2; k >= 0; k--) begin
            if (run && (x[k] == x[DW-1])) cnt = cnt + CW'(1);
            else                          run = 1'b0;
        end
        expo    = (cnt > CW'(EMAX)) ? EW'(EMAX) : EW'(cnt);
        shifted = x << expo;
        y       = {shifted[DW-1 -: MW], expo, {(DW-MW-EW){1'b0}}};
    end
endmodule

// File: rtl/iqf_word_fmt.sv
`timescale 1ns/1ps
module iqf_word_fmt import iqf_pkg::*; #(
    parameter int DW = 32
) (
    input  fmt_e          fmt,
    input  logic [DW-1:0] x,
    output logic [DW-1:0] y
);
    logic [DW-1:0] y_lo, y_hi, y_fl;

    iqf_round #(.DW(DW), .KW(RND_LO_W)) u_rnd_lo (.x(x), .y(y_lo));
    iqf_round #(.DW(DW), .KW(RND_HI_W)) u_rnd_hi (.x(x), .y(y_hi));
    iqf_float #(.DW(DW), .MW(MANT_W), .EW(EXP_W)) u_flt (.x(x), .y(y_fl));

    always_comb begin
        unique case (fmt)
            FMT_TRUNC8: y = x;
            FMT_RND16:  y = y_lo;
            FMT_RND24:  y = y_hi;
            FMT_FLOAT:  y = y_fl;
            default:    y = x;
        endcase
    end
endmodule

// File: rtl/iqf_seq.sv
`timescale 1ns/1ps
module iqf_seq import iqf_pkg::*; (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] wlen,
    input  logic          pair,
    input  logic          mux,
    output logic          accept,
    output logic          drop,
    output logic          busy,
    output logic          sync_en,
    output logic          shift_en,
    output logic [1:0]    seg,
    output logic [LW-1:0] pos
);
    seq_st_e       st_q, st_d;
    logic [1:0]    seg_q, seg_d;
    logic [LW-1:0] pos_q, pos_d;
    logic [1:0]    last_seg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            seg_q <= '0;
            pos_q <= '0;
        end else begin
            st_q  <= st_d;
            seg_q <= seg_d;
            pos_q <= pos_d;
        end
    end

    always_comb begin
        last_seg = mux ? 2'd3 : 2'd1;
        st_d  = st_q;
        seg_d = seg_q;
        pos_d = pos_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_d  = ST_SYNC;
                    seg_d = '0;
                    pos_d = '0;
                end
            end
            ST_SYNC: begin
                st_d  = ST_SHIFT;
                pos_d = '0;
            end
            ST_SHIFT: begin
                if (pos_q == wlen - LW'(1)) begin
                    pos_d = '0;
                    if (seg_q == last_seg) begin
                        st_d = ST_IDLE;
                    end else begin
                        seg_d = seg_q + 2'd1;
                        st_d  = (pair && !seg_q[0]) ? ST_SHIFT : ST_SYNC;
                    end
                end else begin
                    pos_d = pos_q + LW'(1);
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy     = (st_q != ST_IDLE);
        accept   = start && (st_q == ST_IDLE);
        drop     = start && (st_q != ST_IDLE);
        sync_en  = (st_q == ST_SYNC);
        shift_en = (st_q == ST_SHIFT);
        seg      = seg_q;
        pos      = pos_q;
    end
endmodule

// File: rtl/iq_serial_formatter.sv
`timescale 1ns/1ps
module iq_serial_formatter import iqf_pkg::*; #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] a_q,
    input  logic [DW-1:0] b_i,
    input  logic [DW-1:0] b_q,
    input  logic          cfg_fs_inv,
    input  logic          cfg_rdy_inv,
    input  logic          cfg_mux,
    input  logic          cfg_pair,
    input  logic [1:0]    cfg_fmt,
    output logic          sd_a,
    output logic          sd_b,
    output logic          fs,
    output logic          rdy,
    output logic          overrun,
    output logic [DW-1:0] par_a_i,
    output logic [DW-1:0] par_a_q,
    output logic [DW-1:0] par_b_i,
    output logic [DW-1:0] par_b_q
);
    localparam int NW = 4;
    localparam int BW = $clog2(DW);

    cfg_t          cfg_q;
    logic [DW-1:0] raw    [NW];
    logic [DW-1:0] fmtd   [NW];
    logic [DW-1:0] word_q [NW];
    logic          accept, drop, busy, sync_en, shift_en;
    logic [1:0]    seg;
    logic [LW-1:0] pos;
    logic [BW-1:0] bidx;

    assign raw[0] = a_i;
    assign raw[1] = a_q;
    assign raw[2] = b_i;
    assign raw[3] = b_q;

    for (genvar g = 0; g < NW; g++) begin : g_fmt
        iqf_word_fmt #(.DW(DW)) u_fmt (
            .fmt (fmt_e'(cfg_fmt)),
            .x   (raw[g]),
            .y   (fmtd[g])
        );
    end

    iqf_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (in_valid),
        .wlen     (word_len(cfg_q.fmt)),
        .pair     (cfg_q.pair),
        .mux      (cfg_q.mux),
        .accept   (accept),
        .drop     (drop),
        .busy     (busy),
        .sync_en  (sync_en),
        .shift_en (shift_en),
        .seg      (seg),
        .pos      (pos)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            overrun <= 1'b0;
            for (int k = 0; k < NW; k++) word_q[k] <= '0;
        end else begin
            overrun <= drop;
            if (accept) begin
                cfg_q.fs_inv  <= cfg_fs_inv;
                cfg_q.rdy_inv <= cfg_rdy_inv;
                cfg_q.mux     <= cfg_mux;
                cfg_q.pair    <= cfg_pair;
                cfg_q.fmt     <= fmt_e'(cfg_fmt);
                for (int k = 0; k < NW; k++) word_q[k] <= fmtd[k];
            end
        end
    end

    always_comb begin
        bidx    = BW'(DW - 1) - BW'(pos);
        sd_a    = shift_en && word_q[seg][bidx];
        sd_b    = shift_en && !cfg_q.mux && word_q[{1'b1, seg[0]}][bidx];
        fs      = sync_en ^ cfg_q.fs_inv;
        rdy     = busy ^ cfg_q.rdy_inv;
        par_a_i = word_q[0];
        par_a_q = word_q[1];
        par_b_i = word_q[2];
        par_b_q = word_q[3];
    end
endmodule

// File: rtl/iqf_chk.sv
`timescale 1ns/1ps
module iqf_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          fs,
    input logic          rdy,
    input logic          sd_a,
    input logic          sd_b,
    input logic          overrun,
    input logic          fs_inv,
    input logic          rdy_inv,
    input logic          mux,
    input logic [DW-1:0] par_a_i
);
    logic rdy_act, fs_act;
    assign rdy_act = rdy ^ rdy_inv;
    assign fs_act  = fs ^ fs_inv;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_act |-> (!sd_a && !sd_b && !fs_act));

    // R9
    fs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fs_act |=> !fs_act);

    // R8
    mux_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mux && rdy_act) |-> !sd_b);

    // R10
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !rdy_act) |=> (rdy_act && fs_act));

    // R11
    overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rdy_act) |=> overrun);

    // R11
    drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rdy_act) |=> $stable(par_a_i));
endmodule

bind iq_serial_formatter iqf_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .fs       (fs),
    .rdy      (rdy),
    .sd_a     (sd_a),
    .sd_b     (sd_b),
    .overrun  (overrun),
    .fs_inv   (cfg_q.fs_inv),
    .rdy_inv  (cfg_q.rdy_inv),
    .mux      (cfg_q.mux),
    .par_a_i  (par_a_i)
);

// File: tb/sim_iq_serial_formatter.sv
`timescale 1ns/1ps
module sim_iq_serial_formatter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] a_i = '0, a_q = '0, b_i = '0, b_q = '0;
    logic        cfg_fs_inv = 1'b0, cfg_rdy_inv = 1'b0, cfg_mux = 1'b0, cfg_pair = 1'b0;
    logic [1:0]  cfg_fmt = 2'd0;
    logic        sd_a, sd_b, fs, rdy, overrun;
    logic [31:0] par_a_i, par_a_q, par_b_i, par_b_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int n_cyc;
    logic cap_fs [80];
    logic cap_a  [80];
    logic cap_b  [80];

    always #4 clk = ~clk;

    iq_serial_formatter u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_i(a_i), .a_q(a_q), .b_i(b_i), .b_q(b_q),
        .cfg_fs_inv(cfg_fs_inv), .cfg_rdy_inv(cfg_rdy_inv),
        .cfg_mux(cfg_mux), .cfg_pair(cfg_pair), .cfg_fmt(cfg_fmt),
        .sd_a(sd_a), .sd_b(sd_b), .fs(fs), .rdy(rdy), .overrun(overrun),
        .par_a_i(par_a_i), .par_a_q(par_a_q), .par_b_i(par_b_i), .par_b_q(par_b_q)
    );

    localparam int NV = 14;
    localparam logic [1:0] V_FMT [NV] = '{2'd0, 2'd1, 2'd1, 2'd1, 2'd1, 2'd2, 2'd2,
                                          2'd3, 2'd3, 2'd3, 2'd3, 2'd0, 2'd3, 2'd2};
    localparam logic [31:0] V_IN [NV] = '{32'h12345678, 32'h12348000, 32'h12347FFF,
                                          32'h7FFF8000, 32'hFFFF8000, 32'h123456C0,
                                          32'h7FFFFF80, 32'h00010000, 32'h00000000,
                                          32'hC0000000, 32'h40000000, 32'h80000001,
                                          32'hFFFFFFFF, 32'h800000FF};
    localparam logic [31:0] V_PAR [NV] = '{32'h12345678, 32'h12350000, 32'h12340000,
                                           32'h7FFF0000, 32'h00000000, 32'h12345700,
                                           32'h7FFFFF00, 32'h40E00000, 32'h00F00000,
                                           32'h80100000, 32'h40000000, 32'h80000001,
                                           32'hFFF00000, 32'h80000100};

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int serial_len(input logic [1:0] f);
        case (f)
            2'd0:    return 8;
            2'd1:    return 16;
            2'd2:    return 24;
            default: return 12;
        endcase
    endfunction

    function automatic logic [31:0] grab_a(input int st, input int w);
        logic [31:0] v = '0;
        for (int k = 0; k < w; k++) v = {v[30:0], cap_a[st+k]};
        return v;
    endfunction

    function automatic logic [31:0] grab_b(input int st, input int w);
        logic [31:0] v = '0;
        for (int k = 0; k < w; k++) v = {v[30:0], cap_b[st+k]};
        return v;
    endfunction

    function automatic int fs_count();
        int c = 0;
        for (int k = 0; k < n_cyc; k++) if (cap_fs[k]) c++;
        return c;
    endfunction

    function automatic int b_ones();
        int c = 0;
        for (int k = 0; k < n_cyc; k++) if (cap_b[k]) c++;
        return c;
    endfunction

    task automatic run_frame(input logic [31:0] ai, aq, bi, bq,
                             input logic fsi, rdi, mx, pr, input logic [1:0] fm);
        @(negedge clk);
        a_i = ai; a_q = aq; b_i = bi; b_q = bq;
        cfg_fs_inv = fsi; cfg_rdy_inv = rdi; cfg_mux = mx; cfg_pair = pr; cfg_fmt = fm;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        n_cyc = 0;
        while (n_cyc < 80 && ((rdy ^ rdi) == 1'b1)) begin
            cap_fs[n_cyc] = fs ^ fsi;
            cap_a[n_cyc]  = sd_a;
            cap_b[n_cyc]  = sd_b;
            n_cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int w;
        int cnt;
        string rq;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({sd_a, sd_b, fs, rdy, overrun} == 5'b0, "R1", "idle outputs",
            32'({sd_a, sd_b, fs, rdy, overrun}), 32'h0);
        chk(par_a_i == 32'h0 && par_b_q == 32'h0, "R1", "parallel reset", par_a_i, 32'h0);

        // Vector table: formats, per-word framing
        for (int i = 0; i < NV; i++) begin
            w  = serial_len(V_FMT[i]);
            rq = (V_FMT[i] == 2'd0) ? "R2" : (V_FMT[i] == 2'd3) ? "R4" : "R3";
            run_frame(V_IN[i], 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, V_FMT[i]);
            chk(par_a_i == V_PAR[i], rq, "parallel word", par_a_i, V_PAR[i]);
            chk(grab_a(1, w) == (V_PAR[i] >> (32 - w)), {rq, " R5"}, "serial word",
                grab_a(1, w), V_PAR[i] >> (32 - w));
            chk(n_cyc == 2 * w + 2, "R10", "ready length", n_cyc, 2 * w + 2);
            chk(cap_fs[0] && cap_fs[w+1] && fs_count() == 2, "R6", "sync per word",
                fs_count(), 2);
        end

        // R7 pair mode
        run_frame(32'hA5000000, 32'h3C000000, 32'h81000000, 32'h7E000000,
                  1'b0, 1'b0, 1'b0, 1'b1, 2'd0);
        chk(n_cyc == 17, "R7", "pair frame length", n_cyc, 17);
        chk(cap_fs[0] && fs_count() == 1, "R7", "single sync", fs_count(), 1);
        chk(grab_a(1, 16) == 32'hA53C, "R7", "A pair bits", grab_a(1, 16), 32'hA53C);
        chk(grab_b(1, 16) == 32'h817E, "R8", "B pair on own pin", grab_b(1, 16), 32'h817E);

        // R8 mux mode, per-word sync
        run_frame(32'hA5000000, 32'h3C000000, 32'h81000000, 32'h7E000000,
                  1'b0, 1'b0, 1'b1, 1'b0, 2'd0);
        chk(n_cyc == 36, "R8", "mux frame length", n_cyc, 36);
        chk({grab_a(1, 8), grab_a(10, 8), grab_a(19, 8), grab_a(28, 8)} ==
            {32'hA5, 32'h3C, 32'h81, 32'h7E}, "R8", "mux word order",
            {grab_a(1, 8)[7:0], grab_a(10, 8)[7:0], grab_a(19, 8)[7:0], grab_a(28, 8)[7:0]},
            32'hA53C817E);
        chk(cap_fs[0] && cap_fs[9] && cap_fs[18] && cap_fs[27] && fs_count() == 4,
            "R6", "mux sync positions", fs_count(), 4);
        chk(b_ones() == 0, "R8", "sd_b quiet in mux", b_ones(), 0);

        // R8 + R7 mux with pair mode
        run_frame(32'hA5000000, 32'h3C000000, 32'h81000000, 32'h7E000000,
                  1'b0, 1'b0, 1'b1, 1'b1, 2'd0);
        chk(n_cyc == 34, "R7", "mux pair length", n_cyc, 34);
        chk(cap_fs[0] && cap_fs[17] && fs_count() == 2, "R7", "mux pair syncs", fs_count(), 2);
        chk({grab_a(1, 16)[15:0], grab_a(18, 16)[15:0]} == 32'hA53C817E, "R8",
            "mux pair order", {grab_a(1, 16)[15:0], grab_a(18, 16)[15:0]}, 32'hA53C817E);

        // R9 inverted frame-sync
        run_frame(32'h5A000000, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
        chk(cap_fs[0] && cap_fs[9] && fs_count() == 2, "R9", "low sync pulses", fs_count(), 2);
        chk(fs == 1'b1, "R9", "idle level inverted", 32'(fs), 32'h1);

        // R10 inverted ready
        run_frame(32'h5A000000, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0);
        chk(n_cyc == 18, "R10", "low ready length", n_cyc, 18);
        chk(rdy == 1'b1, "R10", "idle ready inverted", 32'(rdy), 32'h1);

        // R11 overrun during a frame
        @(negedge clk);
        a_i = 32'h12348000; cfg_fs_inv = 1'b0; cfg_rdy_inv = 1'b0;
        cfg_mux = 1'b0; cfg_pair = 1'b0; cfg_fmt = 2'd1;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        a_i = 32'h7FFF8000; cfg_fmt = 2'd0; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(overrun == 1'b1, "R11", "overrun flag", 32'(overrun), 32'h1);
        chk(par_a_i == 32'h12350000, "R11", "parallel kept", par_a_i, 32'h12350000);
        cnt = 5;
        @(negedge clk);
        chk(overrun == 1'b0, "R11", "overrun one clock", 32'(overrun), 32'h0);
        while (cnt < 80 && rdy) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == 34, "R11", "frame length unchanged", cnt, 34);
        chk({sd_a, fs} == 2'b00, "R1", "quiet after frame", 32'({sd_a, fs}), 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule